// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into framed asynchronous characters on one serial line. Bytes enter through a single-cycle write strobe and wait either in a one-byte holding slot (legacy mode) or in a 16-entry first-in first-out queue (queued mode). A framing engine, advanced by a 16x oversampling enable from an external rate generator, sends a low start bit, 5 to 8 data bits least significant first, an optional parity bit and 1, 1.5 or 2 high stop bits. Each bit lasts 16 enable ticks, and the line rests high.

Two flags tell the processor or a DMA engine when to refill the buffer. Both are raised halfway through the start bit of a character (8 enable ticks in) if the buffer is empty at that moment. The empty interrupt is dropped by a write or by an interrupt-identification read. The DMA ready flag is dropped by a write in legacy mode, or by the write that fills the queue in queued mode. A transmitter that starts from rest waits 8 ticks before the start bit, so the first interrupt comes 16 ticks after the first load. A break control holds the line low without stopping the framing engine.

Top module: `ser_tx`

## Requirements
- R1: After reset the line `txd` is high, `tx_rdy` is 1, and `thre_irq` equals `thre_ie`, because the empty condition is pending.
- R2: On an enable tick, a transmitter at rest with a byte waiting loads that byte. It then keeps the line high for 8 ticks, sends the start bit low for 16 ticks, and sends the data bits least significant first for 16 ticks each. `char_len` selects 00=5, 01=6, 10=7, 11=8 data bits. The line is high at rest.
- R3: With `parity_en`=1, one parity bit of 16 ticks follows the data. `parity_odd`=0 gives even parity over the data bits and 1 gives odd parity. With `parity_en`=0 no parity bit is sent.
- R4: The stop time is 16 ticks with `stop_long`=0. With `stop_long`=1 it is 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bits.
- R5: If a byte is waiting when the last stop tick ends, its start bit follows at once, with no 8-tick lead.
- R6: `fifo_mode`=1 holds up to 16 bytes and drops writes to a full queue. `fifo_mode`=0 holds one byte, and a write to the occupied slot replaces it. A write in the same cycle as a load counts against the space that the load frees.
- R7: Any change of `fifo_mode` empties the buffer in that cycle and drops a write made in that cycle. A character already being sent finishes.
- R8: On the 8th enable tick of a start bit, the empty interrupt becomes pending if the buffer is empty. `thre_irq` = pending AND `thre_ie`.
- R9: A write (`wr_en`) or an interrupt-identification read (`iid_rd`) clears the pending interrupt. A clear wins over a set in the same cycle.
- R10: `tx_rdy` is set on the same event as R8. With `fifo_mode`=0 any write clears it. With `fifo_mode`=1 only the write that brings the queue to 16 entries clears it. A clear wins over a set.
- R11: While `brk`=1, `txd` is low. The framing engine keeps its timing.
- R12: The character length, parity and stop settings are captured when a byte is loaded and hold for the whole character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_en | input | 1 | 16x oversampling enable, one-cycle pulse per tick |
| fifo_mode | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| char_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | Send a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_long | input | 1 | 0 = 1 stop bit, 1 = 1.5 (5-bit) or 2 stop bits |
| brk | input | 1 | Force the line low |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| iid_rd | input | 1 | Interrupt-identification read, clears the pending empty interrupt |
| thre_ie | input | 1 | Empty interrupt enable |
| txd | output | 1 | Serial output |
| thre_irq | output | 1 | Empty interrupt |
| tx_rdy | output | 1 | DMA transmit-ready flag |

## Verification
A corrupted tick or bit counter moves the edges on `txd`. The error shows within one bit period and grows with each later bit. A wrong buffer count or pointer makes a character appear, vanish or repeat on the line within one character time. It also moves the mid-start-bit instant at which `thre_irq` and `tx_rdy` rise, so the flags disagree in the same cycle that the wrong empty test is made. Captured framing settings that go stale show as a wrong bit count or parity level in the character that follows.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_PAR   = 3'd4,
    ST_STOP  = 3'd5
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;       // 00=5 .. 11=8 data bits
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } frame_cfg_t;

  // Mask that keeps the data bits a character length uses
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

endpackage

// File: rtl/ser_tx_buf.sv
// Byte buffer: DEPTH-entry queue or single slot, selected at run time.
// DEPTH must be a power of two, at least 2.
module ser_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          avail,
  output logic          filled
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q;
  logic          flush, full, push, ovw;

  assign flush = fifo_mode ^ mode_q;
  assign full  = fifo_mode ? (cnt_q == FULL_CNT) : (cnt_q != '0);
  assign push  = wr_en & ~flush & (~full | pop);
  assign ovw   = wr_en & ~flush & ~fifo_mode & full & ~pop;

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = rd_q + AW'(pop);
      wr_d  = wr_q + AW'(push);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      mode_q <= fifo_mode;
    end
  end

  // Storage carries no reset; only written slots are ever read
  always_ff @(posedge clk) begin
    if (push)     mem[wr_q] <= wr_data;
    else if (ovw) mem[rd_q] <= wr_data;
  end

  assign head   = mem[rd_q];
  assign count  = cnt_q;
  assign avail  = (cnt_q != '0) & ~flush;
  assign filled = push & ~pop & fifo_mode & (cnt_q == LAST_CNT);

endmodule

// File: rtl/ser_tx_framer.sv
// Character framing engine advanced by the 16x enable.
module ser_tx_framer
  import ser_tx_pkg::*;
#(
  parameter int OS  = 16,
  localparam int CW = $clog2(2 * OS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_en,
  input  logic       avail,
  input  logic [7:0] head,
  input  frame_cfg_t cfg_in,
  output logic       pop,
  output logic       line,
  output logic       mark_tick
);

  localparam logic [CW-1:0] HALF_LAST   = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] BIT_LAST    = CW'(OS - 1);
  localparam logic [CW-1:0] STOP15_LAST = CW'(OS + OS / 2 - 1);
  localparam logic [CW-1:0] STOP2_LAST  = CW'(2 * OS - 1);

  tx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  frame_cfg_t    cfg_q, cfg_d;
  logic          par_q, par_d;
  logic [CW-1:0] stop_last;
  logic [2:0]    bit_last;

  assign stop_last = !cfg_q.stop_long ? BIT_LAST :
                     (cfg_q.len == 2'b00) ? STOP15_LAST : STOP2_LAST;
  assign bit_last  = {1'b1, cfg_q.len};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    cfg_d = cfg_q;
    par_d = par_q;
    pop   = 1'b0;
    if (baud_en) begin
      cnt_d = cnt_q + 1'b1;
      case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (avail) begin
            pop  = 1'b1;
            st_d = ST_LEAD;
          end
        end
        ST_LEAD: if (cnt_q == HALF_LAST) begin
          st_d  = ST_START;
          cnt_d = '0;
        end
        ST_START: if (cnt_q == BIT_LAST) begin
          st_d  = ST_DATA;
          cnt_d = '0;
          bit_d = '0;
        end
        ST_DATA: if (cnt_q == BIT_LAST) begin
          cnt_d = '0;
          if (bit_q == bit_last) st_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   bit_d = bit_q + 3'd1;
        end
        ST_PAR: if (cnt_q == BIT_LAST) begin
          st_d  = ST_STOP;
          cnt_d = '0;
        end
        ST_STOP: if (cnt_q == stop_last) begin
          cnt_d = '0;
          if (avail) begin
            pop  = 1'b1;
            st_d = ST_START;
          end else begin
            st_d = ST_IDLE;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
      if (pop) begin
        sh_d  = head;
        cfg_d = cfg_in;
        par_d = (^(head & len_mask(cfg_in.len))) ^ cfg_in.par_odd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[bit_q];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign mark_tick = baud_en & (st_q == ST_START) & (cnt_q == HALF_LAST);

endmodule

// File: rtl/ser_tx_flags.sv
// Empty-interrupt pending bit and DMA ready flag.
module ser_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic wr_en,
  input  logic iid_rd,
  input  logic mark_tick,
  input  logic buf_empty,
  input  logic filled,
  output logic pend,
  output logic rdy
);

  logic pend_q, pend_d, rdy_q, rdy_d;
  logic set, rdy_clr;

  assign set     = mark_tick & buf_empty;
  assign rdy_clr = fifo_mode ? filled : wr_en;

  always_comb begin
    pend_d = pend_q;
    if (wr_en | iid_rd) pend_d = 1'b0;
    else if (set)       pend_d = 1'b1;
    rdy_d = rdy_q;
    if (rdy_clr)  rdy_d = 1'b0;
    else if (set) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      rdy_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
    end
  end

  assign pend = pend_q;
  assign rdy  = rdy_q;

endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_en,
  input  logic       fifo_mode,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       stop_long,
  input  logic       brk,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       iid_rd,
  input  logic       thre_ie,
  output logic       txd,
  output logic       thre_irq,
  output logic       tx_rdy
);

  localparam int BCW = $clog2(DEPTH) + 1;

  logic           rst_s0, rst_sync_n;
  logic [7:0]     head;
  logic [BCW-1:0] buf_count;
  logic           avail, filled, pop, line, mark_tick, thre_pend;
  frame_cfg_t     cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  assign cfg_in = '{len: char_len, par_en: parity_en, par_odd: parity_odd,
                    stop_long: stop_long};

  ser_tx_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .fifo_mode(fifo_mode),
    .wr_en(wr_en), .wr_data(wr_data), .pop(pop), .head(head),
    .count(buf_count), .avail(avail), .filled(filled)
  );

  ser_tx_framer #(.OS(OS)) u_framer (
    .clk(clk), .rst_n(rst_sync_n), .baud_en(baud_en), .avail(avail),
    .head(head), .cfg_in(cfg_in), .pop(pop), .line(line),
    .mark_tick(mark_tick)
  );

  ser_tx_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .fifo_mode(fifo_mode), .wr_en(wr_en),
    .iid_rd(iid_rd), .mark_tick(mark_tick), .buf_empty(buf_count == '0),
    .filled(filled), .pend(thre_pend), .rdy(tx_rdy)
  );

  assign txd      = line & ~brk;
  assign thre_irq = thre_pend & thre_ie;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          brk,
  input logic          txd,
  input logic          wr_en,
  input logic          iid_rd,
  input logic          fifo_mode,
  input logic          pend,
  input logic          tx_rdy,
  input logic          mark_tick,
  input logic [CW-1:0] count
);

  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && $stable(fifo_mode)) |=> (count <= CW'(1)));

  assert_mode_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != $past(fifo_mode)) |=> (count == '0));

  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !pend);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iid_rd |=> !pend);

  assert_pend_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(mark_tick && count == '0));

  assert_rdy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(mark_tick && count == '0));

endmodule

bind ser_tx ser_tx_chk #(.DEPTH(DEPTH), .CW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .brk(brk), .txd(txd), .wr_en(wr_en),
  .iid_rd(iid_rd), .fifo_mode(fifo_mode), .pend(thre_pend),
  .tx_rdy(tx_rdy), .mark_tick(mark_tick), .count(buf_count)
);

// File: tb/ser_tx_bench.sv
module ser_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_en = 1'b0, fifo_mode = 1'b0, parity_en = 1'b0;
  logic       parity_odd = 1'b0, stop_long = 1'b0, brk = 1'b0;
  logic       wr_en = 1'b0, iid_rd = 1'b0, thre_ie = 1'b1;
  logic [1:0] char_len = 2'b11;
  logic [7:0] wr_data = 8'h00;
  logic       txd, thre_irq, tx_rdy;

  always #2 clk = ~clk;

  ser_tx u_ser_tx (
    .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .fifo_mode(fifo_mode),
    .char_len(char_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .stop_long(stop_long), .brk(brk), .wr_en(wr_en), .wr_data(wr_data),
    .iid_rd(iid_rd), .thre_ie(thre_ie), .txd(txd), .thre_irq(thre_irq),
    .tx_rdy(tx_rdy)
  );

  int    n_chk = 0, n_fail = 0;
  int    baud_div = 1, tick = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Reference model: one queue entry per enable tick of line level
  int         q_lvl[$];
  bit         q_mk[$];
  logic [7:0] m_buf[$];
  bit         m_pend = 1, m_rdy = 1, m_prev = 0;

  function automatic void put(int lvl, bit mk);
    q_lvl.push_back(lvl);
    q_mk.push_back(mk);
  endfunction

  function automatic void m_build(logic [7:0] d, bit lead);
    int n, sl;
    bit p;
    n = int'(char_len) + 5;
    if (lead) repeat (8) put(1, 0);
    for (int i = 0; i < 16; i++) put(0, i == 7);
    for (int b = 0; b < n; b++) repeat (16) put(int'(d[b]), 0);
    if (parity_en) begin
      p = parity_odd;
      for (int b = 0; b < n; b++) p ^= d[b];
      repeat (16) put(int'(p), 0);
    end
    sl = !stop_long ? 16 : (char_len == 2'b00 ? 24 : 32);
    repeat (sl) put(1, 0);
  endfunction

  always @(posedge clk) begin : mdl
    bit flush, mk, set, acc, clr;
    int oc, cap;
    if (!rst_n) begin
      q_lvl.delete(); q_mk.delete(); m_buf.delete();
      m_pend = 1; m_rdy = 1; m_prev = 0;
    end else begin
      flush = (fifo_mode != m_prev);
      m_prev = fifo_mode;
      oc = m_buf.size();
      mk = 0;
      if (baud_en) begin
        if (q_lvl.size() > 0) begin
          mk = q_mk[0];
          void'(q_lvl.pop_front());
          void'(q_mk.pop_front());
          if (q_lvl.size() == 0 && oc > 0 && !flush) m_build(m_buf.pop_front(), 0);
        end else if (oc > 0 && !flush) begin
          m_build(m_buf.pop_front(), 1);
        end
      end
      acc = 0;
      if (wr_en && !flush) begin
        cap = fifo_mode ? 16 : 1;
        if (m_buf.size() < cap) begin
          m_buf.push_back(wr_data);
          acc = 1;
        end else if (!fifo_mode) begin
          m_buf[0] = wr_data;
        end
      end
      if (flush) m_buf.delete();
      set = mk && (oc == 0);
      if (wr_en || iid_rd) m_pend = 0;
      else if (set)        m_pend = 1;
      clr = fifo_mode ? (acc && m_buf.size() == 16) : wr_en;
      if (clr)      m_rdy = 0;
      else if (set) m_rdy = 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic e_txd;
    @(posedge clk);
    #1;
    if (rst_n) begin
      e_txd = (q_lvl.size() > 0 ? logic'(q_lvl[0][0]) : 1'b1) & ~brk;
      chk({cur_req, " txd"}, txd, e_txd);
      chk({cur_req, " thre_irq"}, thre_irq, m_pend & thre_ie);
      chk({cur_req, " tx_rdy"}, tx_rdy, m_rdy);
    end
    tick++;
    baud_en = (baud_div <= 1) ? 1'b1 : ((tick % baud_div) == 0);
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q_lvl.size() != 0 || m_buf.size() != 0) cyc();
    run(3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    run(4);
    // R1 reset state
    chk("R1 idle txd", txd, 1'b1);
    chk("R1 irq pending", thre_irq, 1'b1);
    chk("R1 rdy", tx_rdy, 1'b1);

    // R2 framing for every length
    cur_req = "R2";
    char_len = 2'b11; wr(8'hA5); drain();
    char_len = 2'b00; wr(8'h13); drain();
    baud_div = 3;
    char_len = 2'b01; wr(8'h2C); drain();
    char_len = 2'b10; wr(8'h5A); drain();
    baud_div = 1;

    // R3 parity
    cur_req = "R3";
    parity_en = 1'b1; char_len = 2'b11;
    parity_odd = 1'b0; wr(8'h37); drain();
    parity_odd = 1'b1; wr(8'h37); drain();
    char_len = 2'b00; wr(8'h1E); drain();
    parity_en = 1'b0; parity_odd = 1'b0;

    // R4 stop lengths
    cur_req = "R4";
    stop_long = 1'b1;
    char_len = 2'b00; wr(8'h09); drain();
    char_len = 2'b11; wr(8'hC3); drain();
    stop_long = 1'b0;

    // R5 back-to-back characters in queued mode
    cur_req = "R5";
    fifo_mode = 1'b1; run(3);
    wr(8'h81); wr(8'h42); wr(8'h24); drain();

    // R6 queue limit, then single-slot replace
    cur_req = "R6";
    baud_div = 4;
    for (int i = 0; i < 18; i++) wr(8'(i * 13 + 7));
    drain();
    fifo_mode = 1'b0; run(3);
    baud_div = 1;
    wr(8'h11); wr(8'h22); wr(8'h33); drain();
    chk("R6 buffer empty after drain", txd, 1'b1);

    // R7 mode change flushes
    cur_req = "R7";
    fifo_mode = 1'b1; run(3);
    baud_div = 4;
    for (int i = 0; i < 6; i++) wr(8'(8'hF0 + i));
    run(20);
    fifo_mode = 1'b0;
    wr(8'h77);
    drain();
    baud_div = 1;

    // R8 interrupt timing and enable
    cur_req = "R8";
    wr(8'h6B);
    run(17);
    chk("R8 irq at start mid", thre_irq, 1'b1);
    thre_ie = 1'b0; run(2);
    chk("R8 masked irq", thre_irq, 1'b0);
    thre_ie = 1'b1; drain();

    // R9 clear by identification read
    cur_req = "R9";
    wr(8'h3C);
    while (!m_pend) cyc();
    iid_rd = 1'b1; cyc(); iid_rd = 1'b0;
    chk("R9 read clears", thre_irq, 1'b0);
    drain();

    // R10 ready flag in queued mode
    cur_req = "R10";
    fifo_mode = 1'b1; run(3);
    baud_div = 2;
    for (int i = 0; i < 17; i++) wr(8'(i * 5 + 1));
    chk("R10 cleared on fill", tx_rdy, 1'b0);
    drain();
    baud_div = 1;
    fifo_mode = 1'b0; run(3);

    // R11 break mid-character
    cur_req = "R11";
    wr(8'h55);
    run(40);
    brk = 1'b1; run(30);
    chk("R11 line low in break", txd, 1'b0);
    brk = 1'b0;
    drain();

    // R12 settings captured at load
    cur_req = "R12";
    char_len = 2'b11; wr(8'hF0);
    run(5);
    char_len = 2'b00; parity_en = 1'b1; stop_long = 1'b1;
    drain();
    parity_en = 1'b0; stop_long = 1'b0; char_len = 2'b11;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog %s actual=running expected=finished", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule